// File: doc/BRIEF.md
# Button-Set Square Wave Generator

This block drives a square wave whose frequency is chosen in whole kilohertz by an 8-bit setting. Two push buttons change the setting. One raises it and the other lowers it. The live setting is shown in binary on eight LED outputs. Each raw button line is synchronised and debounced before use.

A short press moves the setting by one step. If a button is kept down past a hold time, the setting keeps stepping at a fixed repeat interval until the button is let go. The setting stops at its ends and never wraps. Pressing both buttons together freezes it.

The output divider turns the setting into a half-period count from the system clock rate. It restarts that count whenever the setting changes. A setting of zero parks the output low.

Top module: `sqwave_gen`

## Requirements
- R1: While `rst` is high, and on the first cycles after it, `led` is 0 and `wave` is low.
- R2: `led[i]` equals bit i of the current unsigned setting, for i = 0 to 7.
- R3: A raw button level is accepted only after it has held steady for CLK_HZ/1000*DEBOUNCE_MS cycles once synchronised. A pulse shorter than that changes nothing.
- R4: Each accepted press of one button alone gives exactly one step. `btn_up_raw` adds 1 and `btn_dn_raw` subtracts 1. The setting never moves by more than 1 in one cycle.
- R5: If a button is still held, the first automatic step comes exactly CLK_HZ/1000*HOLD_MS cycles after the press step.
- R6: After that, steps repeat every CLK_HZ/1000*REPEAT_MS cycles until the button is released.
- R7: The setting saturates at 255 going up and at 0 going down. It never wraps.
- R8: While both buttons are accepted as pressed, the setting does not change and the hold timer is cleared. When one of them is then released, the other one counts as a fresh press.
- R9: For a setting s > 0, `wave` stays high for h cycles and then low for h cycles, where h = max(1, floor(CLK_HZ/(2000*s))).
- R10: With a setting of 0, `wave` is low from the cycle after the setting reaches 0.
- R11: A change of setting restarts the divider count, so the new half period applies from the next toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| btn_up_raw | input | 1 | Raw increment button, high when pressed |
| btn_dn_raw | input | 1 | Raw decrement button, high when pressed |
| wave | output | 1 | Square wave output |
| led | output | 8 | Current setting in binary, in kHz |

## Verification
A button edge reaches the LEDs after two synchroniser flops, the debounce window, one registered step pulse and the setting register. The bench therefore does not time single presses. Instead, a driver queues the expected LED values in order, and a monitor compares each LED change, sampled on the falling clock edge, against the head of that queue. Any change that was not queued is a failure.

The hold and repeat delays are exact cycle counts between successive LED changes. The monitor records every gap, and the bench compares them with the hold and repeat counts. The wave half periods are counted on falling edges only after the setting has settled, starting from a rising edge of `wave`.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HOLD   = 2'd1,
        PH_REPEAT = 2'd2
    } phase_e;

    // Raw half period in clock cycles; a zero setting is guarded by the caller.
    function automatic logic [31:0] half_cycles(input logic [31:0] clk_hz,
                                                input logic [7:0]  khz);
        logic [31:0] den;
        den = (khz == 8'd0) ? 32'd2000 : 32'd2000 * {24'd0, khz};
        return clk_hz / den;
    endfunction

endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
    parameter int DEB_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          level;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.meta = raw;
        flt_d.sync = flt_q.meta;
        if (flt_q.sync != flt_q.level) begin
            if (flt_q.cnt == CW'(DEB_CYC - 1)) begin
                flt_d.level = flt_q.sync;
                flt_d.cnt   = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + CW'(1);
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flt_q <= '0;
        else     flt_q <= flt_d;
    end

    assign level = flt_q.level;

endmodule

// File: rtl/press_ctl.sv
module press_ctl
    import sqw_pkg::*;
#(
    parameter int HOLD_CYC = 50000000,
    parameter int RPT_CYC  = 5000000
) (
    input  logic clk,
    input  logic rst,
    input  logic up_lvl,
    input  logic dn_lvl,
    output logic step_up,
    output logic step_dn
);
    localparam int TMAX = (HOLD_CYC > RPT_CYC) ? HOLD_CYC : RPT_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        phase_e        phase;
        logic          prev_up;
        logic          prev_dn;
        logic [TW-1:0] tmr;
        logic          up;
        logic          dn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic up_only, dn_only;
    logic [TW-1:0] limit;

    always_comb begin
        up_only = up_lvl & ~dn_lvl;
        dn_only = dn_lvl & ~up_lvl;
        limit   = (ctl_q.phase == PH_HOLD) ? TW'(HOLD_CYC - 1) : TW'(RPT_CYC - 1);

        ctl_d         = ctl_q;
        ctl_d.up      = 1'b0;
        ctl_d.dn      = 1'b0;
        ctl_d.prev_up = up_only;
        ctl_d.prev_dn = dn_only;

        if (!(up_only || dn_only)) begin
            // idle or both pressed: no step, timer cleared
            ctl_d.phase = PH_IDLE;
            ctl_d.tmr   = '0;
        end else if ((up_only && !ctl_q.prev_up) || (dn_only && !ctl_q.prev_dn)) begin
            ctl_d.up    = up_only;
            ctl_d.dn    = dn_only;
            ctl_d.phase = PH_HOLD;
            ctl_d.tmr   = '0;
        end else if (ctl_q.tmr == limit) begin
            ctl_d.up    = up_only;
            ctl_d.dn    = dn_only;
            ctl_d.phase = PH_REPEAT;
            ctl_d.tmr   = '0;
        end else begin
            ctl_d.tmr = ctl_q.tmr + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{phase: PH_IDLE, default: '0};
        else     ctl_q <= ctl_d;
    end

    assign step_up = ctl_q.up;
    assign step_dn = ctl_q.dn;

endmodule

// File: rtl/wave_div.sv
module wave_div
    import sqw_pkg::*;
#(
    parameter int CLK_HZ = 50000000,
    parameter int SW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] setting,
    output logic          wave
);
    localparam int HMAX = CLK_HZ / 2000;
    localparam int HW   = $clog2(HMAX + 1);

    typedef struct packed {
        logic [SW-1:0] prev;
        logic [HW-1:0] cnt;
        logic          out;
    } div_t;

    div_t div_d, div_q;
    logic [31:0]   raw_half;
    logic [HW-1:0] half;

    always_comb begin
        raw_half = half_cycles(32'(CLK_HZ), 8'(setting));
        half     = (raw_half == 32'd0) ? HW'(1) : HW'(raw_half);

        div_d      = div_q;
        div_d.prev = setting;
        if (setting == '0) begin
            div_d.out = 1'b0;
            div_d.cnt = '0;
        end else if (setting != div_q.prev) begin
            div_d.cnt = '0;
        end else if (div_q.cnt >= half - HW'(1)) begin
            div_d.cnt = '0;
            div_d.out = ~div_q.out;
        end else begin
            div_d.cnt = div_q.cnt + HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign wave = div_q.out;

endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen #(
    parameter int CLK_HZ      = 50000000,
    parameter int DEBOUNCE_MS = 10,
    parameter int HOLD_MS     = 1000,
    parameter int REPEAT_MS   = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_up_raw,
    input  logic       btn_dn_raw,
    output logic       wave,
    output logic [7:0] led
);
    localparam int SW       = 8;
    localparam int CYC_MS   = CLK_HZ / 1000;
    localparam int DEB_CYC  = CYC_MS * DEBOUNCE_MS;
    localparam int HOLD_CYC = CYC_MS * HOLD_MS;
    localparam int RPT_CYC  = CYC_MS * REPEAT_MS;
    localparam logic [SW-1:0] TOP = '1;

    typedef struct packed {
        logic [SW-1:0] setting;
    } set_t;

    set_t set_d, set_q;
    logic up_lvl, dn_lvl;
    logic step_up, step_dn;

    btn_filter #(.DEB_CYC(DEB_CYC)) u_flt_up (
        .clk(clk), .rst(rst), .raw(btn_up_raw), .level(up_lvl)
    );

    btn_filter #(.DEB_CYC(DEB_CYC)) u_flt_dn (
        .clk(clk), .rst(rst), .raw(btn_dn_raw), .level(dn_lvl)
    );

    press_ctl #(.HOLD_CYC(HOLD_CYC), .RPT_CYC(RPT_CYC)) u_ctl (
        .clk(clk), .rst(rst), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .step_up(step_up), .step_dn(step_dn)
    );

    always_comb begin
        set_d = set_q;
        if (step_up && set_q.setting != TOP)
            set_d.setting = set_q.setting + SW'(1);
        else if (step_dn && set_q.setting != '0)
            set_d.setting = set_q.setting - SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) set_q <= '0;
        else     set_q <= set_d;
    end

    wave_div #(.CLK_HZ(CLK_HZ), .SW(SW)) u_div (
        .clk(clk), .rst(rst), .setting(set_q.setting), .wave(wave)
    );

    assign led = set_q.setting;

endmodule

// File: rtl/sqwave_gen_chk.sv
module sqwave_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] led,
    input logic       wave,
    input logic       up_lvl,
    input logic       dn_lvl
);
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(led) |-> ((9'(led) == 9'($past(led)) + 9'd1) ||
                           (9'(led) + 9'd1 == 9'($past(led))))); // R4

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        ($past(led) == 8'hFF) |-> (led != 8'h00)); // R7

    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (rst)
        ($past(led) == 8'h00) |-> (led != 8'hFF)); // R7

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(led) == 8'h00) |-> !wave); // R10

    AST_BOTH_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (up_lvl && dn_lvl && $past(up_lvl && dn_lvl)) |=> $stable(led)); // R8

endmodule

bind sqwave_gen sqwave_gen_chk u_chk (
    .clk(clk), .rst(rst), .led(led), .wave(wave),
    .up_lvl(up_lvl), .dn_lvl(dn_lvl)
);

// File: tb/tb_sqwave_gen.sv
module tb_sqwave_gen;
    localparam int CLK_HZ  = 64000;
    localparam int DEB_MS  = 1;
    localparam int HOLD_MS = 8;
    localparam int RPT_MS  = 2;
    localparam int HOLD_C  = CLK_HZ / 1000 * HOLD_MS;
    localparam int RPT_C   = CLK_HZ / 1000 * RPT_MS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up = 1'b0;
    logic dn = 1'b0;
    logic wave;
    logic [7:0] led;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;
    logic [7:0] last_led = 8'd0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    int gap_q[$];
    int model = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sqwave_gen #(.CLK_HZ(CLK_HZ), .DEBOUNCE_MS(DEB_MS),
                 .HOLD_MS(HOLD_MS), .REPEAT_MS(RPT_MS)) dut (
        .clk(clk), .rst(rst), .btn_up_raw(up), .btn_dn_raw(dn),
        .wave(wave), .led(led)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: every LED change must match the head of the expected queue
    always @(negedge clk) begin
        cyc++;
        if (!rst && led !== last_led) begin
            gap_q.push_back(cyc - last_cyc);
            last_cyc = cyc;
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected setting change", int'(led), int'(last_led));
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(led === e, t, int'(led), int'(e));
            end
            last_led = led;
        end
    end

    task automatic expect_step(input bit go_up, input string tag);
        if (go_up && model < 255) model++;
        else if (!go_up && model > 0) model--;
        exp_q.push_back(8'(model));
        tag_q.push_back(tag);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tap(input bit go_up, input int n);
        for (int i = 0; i < n; i++) begin
            expect_step(go_up, go_up ? "R4 R2 press up" : "R4 R2 press down");
            if (go_up) up = 1'b1; else dn = 1'b1;
            wait_cyc(200);
            up = 1'b0; dn = 1'b0;
            wait_cyc(200);
        end
    endtask

    task automatic measure(input int half, input string tag);
        int g, hi, lo;
        g = 0;
        while (wave !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
        while (wave !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
        hi = 0;
        while (wave === 1'b1 && hi < 2000) begin @(negedge clk); hi++; end
        lo = 0;
        while (wave === 1'b0 && lo < 2000) begin @(negedge clk); lo++; end
        check(hi == half, {tag, " high time"}, hi, half);
        check(lo == half, {tag, " low time"}, lo, half);
    endtask

    initial begin
        int bad;
        wait_cyc(5);
        check(led === 8'd0, "R1 led in reset", int'(led), 0);
        check(wave === 1'b0, "R1 wave in reset", int'(wave), 0);
        rst = 1'b0;
        begin
            int hits = 0;
            for (int i = 0; i < 200; i++) begin @(negedge clk); if (wave !== 1'b0) hits++; end
            check(hits == 0, "R10 wave low at zero", hits, 0);
        end

        // glitch shorter than debounce window
        up = 1'b1; wait_cyc(30); up = 1'b0; wait_cyc(300);
        check(led === 8'd0, "R3 short pulse ignored", int'(led), 0);

        tap(1'b1, 5);
        check(led === 8'd5, "R2 led after five ups", int'(led), 5);
        measure(6, "R9 R11 s=5");

        tap(1'b0, 1);
        check(led === 8'd4, "R4 led after one down", int'(led), 4);
        measure(8, "R9 R11 s=4");

        // both together: frozen
        up = 1'b1; dn = 1'b1; wait_cyc(3 * HOLD_C + 100);
        up = 1'b0; dn = 1'b0; wait_cyc(300);
        check(led === 8'd4, "R8 both pressed no change", int'(led), 4);

        // timer cleared by second button, release counts as fresh press
        expect_step(1'b1, "R8 up press");
        up = 1'b1; wait_cyc(200);
        expect_step(1'b1, "R8 fresh press after other released");
        dn = 1'b1; wait_cyc(100); dn = 1'b0;
        wait_cyc(400); up = 1'b0; wait_cyc(300);
        check(led === 8'd6, "R8 led after overlap", int'(led), 6);

        // hold up to saturation
        gap_q.delete();
        for (int i = 0; i < 255; i++) expect_step(1'b1, "R6 R7 auto up");
        while (exp_q.size() > 0 && exp_q[exp_q.size()-1] == 8'd255 &&
               exp_q.size() > 1 && exp_q[exp_q.size()-2] == 8'd255) begin
            void'(exp_q.pop_back()); void'(tag_q.pop_back());
        end
        up = 1'b1; wait_cyc(HOLD_C + 250 * RPT_C + 2000);
        up = 1'b0; wait_cyc(300);
        check(led === 8'd255, "R7 saturated at top", int'(led), 255);
        check(exp_q.size() == 0, "R6 all up steps seen", exp_q.size(), 0);
        check(gap_q.size() > 2 && gap_q[1] == HOLD_C, "R5 hold delay",
              gap_q.size() > 2 ? gap_q[1] : -1, HOLD_C);
        bad = 0;
        for (int i = 2; i < gap_q.size(); i++) if (gap_q[i] != RPT_C) bad++;
        check(bad == 0, "R6 repeat interval mismatches", bad, 0);
        measure(1, "R9 s=255");

        // hold down to zero
        for (int i = 0; i < 255; i++) expect_step(1'b0, "R6 R7 auto down");
        dn = 1'b1; wait_cyc(HOLD_C + 255 * RPT_C + 2000);
        dn = 1'b0; wait_cyc(300);
        check(led === 8'd0, "R7 saturated at bottom", int'(led), 0);
        check(exp_q.size() == 0, "R6 all down steps seen", exp_q.size(), 0);
        begin
            int hits = 0;
            for (int i = 0; i < 200; i++) begin @(negedge clk); if (wave !== 1'b0) hits++; end
            check(hits == 0, "R10 wave low after return to zero", hits, 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule